// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a physical address. It walks a radix page table held in memory, one level at a time, and then checks whether the access is allowed. A request carries the virtual address and the access type. At the moment the request is accepted, the block also takes in the table root address, a supervisor flag, a translation-enable flag and a memory size bound. Descriptors are fetched through a simple read port that allows one read in flight at a time. The answer comes back as a physical address or as a fault tagged with the access type.

With translation disabled, the block maps each address to itself inside the memory bound and does no permission check. With translation enabled, a descriptor is one of three things:

- an invalid entry, which ends the walk with a fault;
- a pointer to the next table;
- a leaf.

A leaf found above the last level maps a large page. The untranslated virtual page bits are merged into it, so it acts like a base page. The resulting page base must lie below the memory bound. The permission field is read from the user group or the supervisor group, depending on privilege.

Top module: `pt_walker`

## Requirements
- R1: `req_ready` is high only while no request is in progress. The address, access type, supervisor flag, translation flag, table root and memory bound are all captured when `req_valid && req_ready`. A response stays on `rsp_valid`, `rsp_paddr`, `rsp_fault` and `rsp_kind`, unchanged, until `rsp_ready` is seen.
- R2: With `vm_on` low, the response comes one cycle after acceptance and needs no memory read. An address below `mem_bound` returns itself with no fault, for any access type. An address at or above the bound faults.
- R3: With `vm_on` high, level 0 reads at the table root. Each level L reads at table base + 8 × index, where the index is the 10 virtual address bits starting at bit PGSHIFT + 10·(LEVELS−1−L). PGSHIFT is 13 and LEVELS is 3 by default. Only one read is outstanding, and the next level is requested only after the data of the previous read arrives.
- R4: Descriptor bit 0 is valid and bit 1 means "points to a table". Valid low faults. Valid and table high continues the walk at the descriptor with its low PGSHIFT bits cleared. If that happens at the last level, the walk faults instead.
- R5: A leaf found at level L < LEVELS−1 has the virtual address bits [PGSHIFT + 10·(LEVELS−1−L) − 1 : PGSHIFT] ORed into its page number.
- R6: A leaf whose page base (after the merge of R5) is not below the captured memory bound faults.
- R7: Permission bits are user-read 3, user-write 4, user-execute 5, supervisor-read 6, supervisor-write 7 and supervisor-execute 8. A fetch needs execute, a store needs write and any other access needs read. The supervisor group is used when the supervisor flag is set, and the user group otherwise.
- R8: A translation that succeeds returns the page base ORed with the low PGSHIFT bits of the virtual address. A fault returns address zero.
- R9: `req_kind` encodes 0 = fetch, 1 = load, 2 = store; code 3 is handled as a load. `rsp_kind` reports the normalized type 0, 1 or 2 with every response, including faults.
- R10: A descriptor read request keeps `mem_req_valid` high and `mem_req_addr` stable until `mem_req_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | XLEN | Virtual address |
| req_kind | input | 2 | Access type (0 fetch, 1 load, 2 store, 3 load) |
| priv_super | input | 1 | Supervisor privilege flag |
| vm_on | input | 1 | Translation enable |
| pt_root | input | XLEN | Level-0 table base |
| mem_bound | input | XLEN | Memory size bound |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | XLEN | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | XLEN | Descriptor read data |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_paddr | output | XLEN | Physical address, zero on fault |
| rsp_fault | output | 1 | Translation or permission fault |
| rsp_kind | output | 2 | Normalized access type of the result |

## Verification
The walker is driven with several kinds of walk, and each separates failure modes that the others cannot:

- **Three-level walks to base pages**, with every access type under both privileges. These separate a wrong permission group or wrong bit choice from a correct table walk.
- **Leaves at levels 0 and 1.** These expose missing or misplaced merging of the virtual page bits. One large-page case merges its way past the memory bound.
- **Invalid entries at the first and last level, and a table pointer at the last level.** These tell early termination apart from a walk that runs past the end.
- **Leaves just below, at and above the bound.**
- **Untranslated requests, including a high address.** These confirm the identity path and its bound check.

Each descriptor read address is compared in order against the walk expected from the requirements. The read port and the result port are stalled in recurring patterns to expose lost or altered handshakes. The request inputs are scrambled after every acceptance to expose values that were not captured.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_FETCH,
        W_WAIT,
        W_DONE
    } wstate_e;

    typedef struct packed {
        acc_e kind;
        logic sup;
    } req_attr_t;

    localparam int DB_VALID = 0;
    localparam int DB_TABLE = 1;

    // code 3 is handled as a load
    function automatic acc_e norm_kind(input logic [1:0] k);
        acc_e r;
        unique case (k)
            2'd0:    r = ACC_FETCH;
            2'd2:    r = ACC_STORE;
            default: r = ACC_LOAD;
        endcase
        return r;
    endfunction

    // perms holds descriptor bits 8..3
    function automatic logic perm_ok(input logic [5:0] perms, input logic sup, input acc_e k);
        logic [2:0] grp;
        logic       ok;
        grp = sup ? perms[5:3] : perms[2:0];
        unique case (k)
            ACC_FETCH: ok = grp[2];
            ACC_STORE: ok = grp[1];
            default:   ok = grp[0];
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pw_desc_addr.sv
module pw_desc_addr #(
    parameter int XLEN     = 64,
    parameter int LEVELS   = 3,
    parameter int IDX_BITS = 10,
    parameter int PGSHIFT  = 13
) (
    input  logic [XLEN-1:0]                                table_base,
    input  logic [XLEN-1:0]                                vaddr,
    input  logic [(LEVELS > 1 ? $clog2(LEVELS) : 1)-1:0]   level,
    output logic [XLEN-1:0]                                desc_addr
);
    localparam int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int ENTRY_SHIFT = $clog2(XLEN / 8);
    localparam int VA_TOP      = PGSHIFT + IDX_BITS * LEVELS;

    logic [IDX_BITS-1:0] idx_at [LEVELS];
    logic [IDX_BITS-1:0] idx;

    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx_at[g] = vaddr[PGSHIFT + IDX_BITS * (LEVELS - 1 - g) +: IDX_BITS];
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) idx = idx_at[i];
        end
    end

    assign desc_addr = table_base + (XLEN'(idx) << ENTRY_SHIFT);

    logic unused_va_bits;
    assign unused_va_bits = ^{vaddr[XLEN-1:VA_TOP], vaddr[PGSHIFT-1:0]};
endmodule

// File: rtl/pw_leaf_eval.sv
module pw_leaf_eval
    import ptw_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int LEVELS   = 3,
    parameter int IDX_BITS = 10,
    parameter int PGSHIFT  = 13
) (
    input  logic [XLEN-1:0]                                desc,
    input  logic [XLEN-1:0]                                vaddr,
    input  logic [(LEVELS > 1 ? $clog2(LEVELS) : 1)-1:0]   level,
    input  req_attr_t                                      attr,
    input  logic [XLEN-1:0]                                bound,
    output logic [XLEN-1:0]                                paddr,
    output logic                                           fault
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic [XLEN-1:0] fill_at [LEVELS];
    logic [XLEN-1:0] fill;
    logic [XLEN-1:0] page_base;
    logic            in_range;
    logic            allowed;

    for (genvar g = 0; g < LEVELS; g++) begin : g_fill
        localparam int REM_BITS = IDX_BITS * (LEVELS - 1 - g);
        if (REM_BITS == 0) begin : g_base
            assign fill_at[g] = '0;
        end else begin : g_super
            assign fill_at[g] = {{(XLEN - REM_BITS - PGSHIFT){1'b0}},
                                 vaddr[PGSHIFT +: REM_BITS],
                                 {PGSHIFT{1'b0}}};
        end
    end

    always_comb begin
        fill = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (level == LVL_W'(i)) fill = fill_at[i];
        end
    end

    assign page_base = {desc[XLEN-1:PGSHIFT], {PGSHIFT{1'b0}}} | fill;
    assign in_range  = page_base < bound;
    assign allowed   = desc[DB_VALID] && perm_ok(desc[8:3], attr.sup, attr.kind);
    assign fault     = !(in_range && allowed);
    assign paddr     = fault ? '0 : (page_base | {{(XLEN-PGSHIFT){1'b0}}, vaddr[PGSHIFT-1:0]});

    logic unused_desc_bits;
    assign unused_desc_bits = ^{desc[PGSHIFT-1:9], desc[2:1]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int LEVELS   = 3,
    parameter int IDX_BITS = 10,
    parameter int PGSHIFT  = 13
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [XLEN-1:0] req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic            priv_super,
    input  logic            vm_on,
    input  logic [XLEN-1:0] pt_root,
    input  logic [XLEN-1:0] mem_bound,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic [XLEN-1:0] mem_req_addr,
    input  logic            mem_rsp_valid,
    input  logic [XLEN-1:0] mem_rsp_data,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [XLEN-1:0] rsp_paddr,
    output logic            rsp_fault,
    output logic [1:0]      rsp_kind
);
    localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    wstate_e          state_q;
    logic [LVL_W-1:0] level_q;
    logic [XLEN-1:0]  base_q;
    logic [XLEN-1:0]  vaddr_q;
    logic [XLEN-1:0]  bound_q;
    req_attr_t        attr_q;
    logic [XLEN-1:0]  paddr_q;
    logic             fault_q;

    logic [XLEN-1:0]  leaf_paddr;
    logic             leaf_fault;

    pw_desc_addr #(
        .XLEN(XLEN), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PGSHIFT(PGSHIFT)
    ) u_addr (
        .table_base (base_q),
        .vaddr      (vaddr_q),
        .level      (level_q),
        .desc_addr  (mem_req_addr)
    );

    pw_leaf_eval #(
        .XLEN(XLEN), .LEVELS(LEVELS), .IDX_BITS(IDX_BITS), .PGSHIFT(PGSHIFT)
    ) u_leaf (
        .desc   (mem_rsp_data),
        .vaddr  (vaddr_q),
        .level  (level_q),
        .attr   (attr_q),
        .bound  (bound_q),
        .paddr  (leaf_paddr),
        .fault  (leaf_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= W_IDLE;
            level_q <= '0;
            base_q  <= '0;
            vaddr_q <= '0;
            bound_q <= '0;
            attr_q  <= '{kind: ACC_FETCH, sup: 1'b0};
            paddr_q <= '0;
            fault_q <= 1'b0;
        end else begin
            unique case (state_q)
                W_IDLE: begin
                    if (req_valid) begin
                        vaddr_q <= req_vaddr;
                        bound_q <= mem_bound;
                        base_q  <= pt_root;
                        attr_q  <= '{kind: norm_kind(req_kind), sup: priv_super};
                        level_q <= '0;
                        if (vm_on) begin
                            state_q <= W_FETCH;
                        end else begin
                            fault_q <= !(req_vaddr < mem_bound);
                            paddr_q <= (req_vaddr < mem_bound) ? req_vaddr : '0;
                            state_q <= W_DONE;
                        end
                    end
                end
                W_FETCH: begin
                    if (mem_req_ready) state_q <= W_WAIT;
                end
                W_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (!mem_rsp_data[DB_VALID]) begin
                            fault_q <= 1'b1;
                            paddr_q <= '0;
                            state_q <= W_DONE;
                        end else if (mem_rsp_data[DB_TABLE]) begin
                            if (level_q == LAST_LVL) begin
                                fault_q <= 1'b1;
                                paddr_q <= '0;
                                state_q <= W_DONE;
                            end else begin
                                base_q  <= {mem_rsp_data[XLEN-1:PGSHIFT], {PGSHIFT{1'b0}}};
                                level_q <= level_q + LVL_W'(1);
                                state_q <= W_FETCH;
                            end
                        end else begin
                            fault_q <= leaf_fault;
                            paddr_q <= leaf_paddr;
                            state_q <= W_DONE;
                        end
                    end
                end
                W_DONE: begin
                    if (rsp_ready) state_q <= W_IDLE;
                end
                default: state_q <= W_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == W_IDLE);
    assign mem_req_valid = (state_q == W_FETCH);
    assign rsp_valid     = (state_q == W_DONE);
    assign rsp_paddr     = paddr_q;
    assign rsp_fault     = fault_q;
    assign rsp_kind      = attr_q.kind;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int XLEN    = 64,
    parameter int PGSHIFT = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic [XLEN-1:0] req_vaddr,
    input logic            vm_on,
    input logic [XLEN-1:0] mem_bound,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic [XLEN-1:0] mem_req_addr,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [XLEN-1:0] rsp_paddr,
    input logic            rsp_fault,
    input logic [1:0]      rsp_kind
);
    logic [XLEN-1:0] va_seen;
    logic [XLEN-1:0] bound_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_seen    <= '0;
            bound_seen <= '0;
        end else if (req_valid && req_ready) begin
            va_seen    <= req_vaddr;
            bound_seen <= mem_bound;
        end
    end

    logic unused_va_seen;
    assign unused_va_seen = ^va_seen[XLEN-1:PGSHIFT];

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_req_valid && !rsp_valid)); // R1

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault) && $stable(rsp_kind)); // R1

    AST_VMOFF_MAP: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && !vm_on |=> rsp_valid
            && (rsp_fault == ($past(req_vaddr) >= $past(mem_bound)))
            && (rsp_fault || (rsp_paddr == $past(req_vaddr)))); // R2

    AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready |=> !mem_req_valid); // R3

    AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R10

    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> rsp_paddr[PGSHIFT-1:0] == va_seen[PGSHIFT-1:0]); // R8

    AST_BASE_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_fault |-> ((rsp_paddr >> PGSHIFT) << PGSHIFT) < bound_seen); // R6
endmodule

bind pt_walker pt_walker_chk #(.XLEN(XLEN), .PGSHIFT(PGSHIFT)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .vm_on         (vm_on),
    .mem_bound     (mem_bound),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .rsp_kind      (rsp_kind)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
    localparam logic [63:0] ROOT  = 64'h10000;
    localparam logic [63:0] T1    = 64'h12000;
    localparam logic [63:0] T2    = 64'h14000;
    localparam logic [63:0] BOUND = 64'h100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        priv_super = 1'b0;
    logic        vm_on = 1'b0;
    logic [63:0] pt_root = '0;
    logic [63:0] mem_bound = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_kind;

    always #2.5 clk = ~clk;

    pt_walker i_pt_walker (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .priv_super(priv_super), .vm_on(vm_on),
        .pt_root(pt_root), .mem_bound(mem_bound),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_kind(rsp_kind)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    logic [63:0] pt_mem [logic [63:0]];

    logic [63:0] epa_q [$];
    logic        eflt_q [$];
    logic [1:0]  ekd_q [$];
    string       etag_q [$];
    logic [63:0] addr_q [$];
    string       atag_q [$];

    function automatic logic [63:0] mkva(int i0, int i1, int i2, int off);
        return (64'(i0) << 33) | (64'(i1) << 23) | (64'(i2) << 13) | 64'(off);
    endfunction

    function automatic logic [63:0] rd(logic [63:0] a);
        if (pt_mem.exists(a)) return pt_mem[a];
        return 64'd0;
    endfunction

    // reference walk from the requirements; queues expected read addresses (R3)
    task automatic ref_walk(input logic [63:0] va, input logic [1:0] k, input logic s,
                            input logic v, input string tag,
                            output logic [63:0] pa, output logic flt, output logic [1:0] kd);
        logic [63:0] base;
        kd  = (k == 2'd3) ? 2'd1 : k;
        pa  = '0;
        flt = 1'b1;
        if (!v) begin
            flt = (va >= BOUND);
            pa  = flt ? 64'd0 : va;
        end else begin
            base = ROOT;
            for (int lvl = 0; lvl < 3; lvl++) begin
                logic [63:0] idx, a, d, mask, pb;
                logic [2:0]  grp;
                logic        need;
                int          rem;
                idx = (va >> (13 + 10 * (2 - lvl))) & 64'h3FF;
                a   = base + idx * 8;
                addr_q.push_back(a);
                atag_q.push_back(tag);
                d = rd(a);
                if (!d[0]) break;
                if (d[1]) begin
                    if (lvl == 2) break;
                    base = d & ~64'h1FFF;
                    continue;
                end
                rem  = 10 * (2 - lvl);
                mask = ((64'd1 << rem) - 1) << 13;
                pb   = (d & ~64'h1FFF) | (va & mask);
                grp  = s ? d[8:6] : d[5:3];
                need = (kd == 2'd0) ? grp[2] : (kd == 2'd2) ? grp[1] : grp[0];
                flt  = !(pb < BOUND) || !need;
                pa   = flt ? 64'd0 : (pb | (va & 64'h1FFF));
                break;
            end
        end
    endtask

    task automatic send(input logic [63:0] va, input logic [1:0] k, input logic s,
                        input logic v, input string tag);
        logic [63:0] pa;
        logic        flt;
        logic [1:0]  kd;
        ref_walk(va, k, s, v, tag, pa, flt, kd);
        epa_q.push_back(pa);
        eflt_q.push_back(flt);
        ekd_q.push_back(kd);
        etag_q.push_back(tag);
        @(negedge clk);
        req_valid  = 1'b1;
        req_vaddr  = va;
        req_kind   = k;
        priv_super = s;
        vm_on      = v;
        pt_root    = ROOT;
        mem_bound  = BOUND;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        // scramble the captured inputs while the walk runs (R1)
        req_valid  = 1'b0;
        req_vaddr  = 64'hFFFF_FFFF_FFFF_FFFF;
        req_kind   = ~k;
        priv_super = ~s;
        vm_on      = ~v;
        pt_root    = 64'hDEAD_0000;
        mem_bound  = 64'd0;
    endtask

    // memory model with a stalling request port; checks each read address (R3, R10)
    logic        pend = 1'b0;
    logic [63:0] pend_addr = '0;
    always @(negedge clk) begin
        cyc = cyc + 1;
        mem_rsp_valid = 1'b0;
        if (pend) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = rd(pend_addr);
            pend = 1'b0;
        end
        mem_req_ready = (cyc % 3) != 0;
        if (!rst && mem_req_valid && mem_req_ready) begin
            n_chk = n_chk + 1;
            if (addr_q.size() == 0) begin
                n_fail = n_fail + 1;
                $display("FAIL R3: unexpected read addr=%h expected none", mem_req_addr);
            end else begin
                if (mem_req_addr !== addr_q[0]) begin
                    n_fail = n_fail + 1;
                    $display("FAIL R3 [%s]: read addr=%h expected %h", atag_q[0], mem_req_addr, addr_q[0]);
                end
                void'(addr_q.pop_front());
                void'(atag_q.pop_front());
            end
            pend = 1'b1;
            pend_addr = mem_req_addr;
        end
    end

    // scoreboard monitor with a stalling result port (R1)
    int mon_cnt = 0;
    always @(negedge clk) begin
        mon_cnt = mon_cnt + 1;
        rsp_ready = (mon_cnt % 4) != 1;
        if (!rst && rsp_valid && rsp_ready) begin
            n_chk = n_chk + 1;
            if (epa_q.size() == 0) begin
                n_fail = n_fail + 1;
                $display("FAIL R1: unexpected result paddr=%h expected none", rsp_paddr);
            end else begin
                if (rsp_paddr !== epa_q[0] || rsp_fault !== eflt_q[0] || rsp_kind !== ekd_q[0]) begin
                    n_fail = n_fail + 1;
                    $display("FAIL %s: paddr=%h fault=%b kind=%0d expected paddr=%h fault=%b kind=%0d",
                             etag_q[0], rsp_paddr, rsp_fault, rsp_kind, epa_q[0], eflt_q[0], ekd_q[0]);
                end
                void'(epa_q.pop_front());
                void'(eflt_q.pop_front());
                void'(ekd_q.pop_front());
                void'(etag_q.pop_front());
            end
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    bit done = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        pt_mem[ROOT + 1*8] = T1 | 64'h3;
        pt_mem[ROOT + 2*8] = 64'h39;
        pt_mem[T1 + 2*8]   = T2 | 64'h3;
        pt_mem[T1 + 6*8]   = 64'h80039;
        pt_mem[T2 + 3*8]   = 64'h401F9;
        pt_mem[T2 + 4*8]   = 64'h42009;
        pt_mem[T2 + 5*8]   = 64'h44041;
        pt_mem[T2 + 10*8]  = 64'h200039;
        pt_mem[T2 + 11*8]  = 64'h100039;
        pt_mem[T2 + 12*8]  = 64'hFE039;
        pt_mem[T2 + 13*8]  = 64'h16003;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready === 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
        check(rsp_valid === 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check(mem_req_valid === 1'b0, "R3 reset mem_req_valid", 64'(mem_req_valid), 64'd0);

        send(mkva(1,2,3,12'h123), 2'd1, 1'b0, 1'b1, "R8 base page load");
        send(mkva(1,2,3,13'h1FFF), 2'd0, 1'b1, 1'b1, "R7 sup fetch all perms");
        send(mkva(1,2,4,8'h10), 2'd1, 1'b0, 1'b1, "R7 user read ok");
        send(mkva(1,2,4,8'h10), 2'd2, 1'b0, 1'b1, "R9 user store fault kind");
        send(mkva(1,2,4,8'h10), 2'd0, 1'b0, 1'b1, "R9 user fetch fault kind");
        send(mkva(1,2,4,8'h10), 2'd3, 1'b0, 1'b1, "R9 code 3 as load");
        send(mkva(1,2,5,8'h08), 2'd1, 1'b1, 1'b1, "R7 sup read ok");
        send(mkva(1,2,5,8'h08), 2'd2, 1'b1, 1'b1, "R7 sup store fault");
        send(mkva(1,2,5,8'h08), 2'd1, 1'b0, 1'b1, "R7 user uses user bits");
        send(mkva(1,6,7,8'h55), 2'd2, 1'b0, 1'b1, "R5 level1 merge");
        send(mkva(2,0,9,8'h10), 2'd1, 1'b0, 1'b1, "R5 level0 merge");
        send(mkva(2,1,0,0), 2'd1, 1'b0, 1'b1, "R6 merged base past bound");
        send(mkva(3,0,0,0), 2'd1, 1'b0, 1'b1, "R4 invalid at level 0");
        send(mkva(1,2,8,0), 2'd1, 1'b0, 1'b1, "R4 invalid at last level");
        send(mkva(1,2,13,0), 2'd1, 1'b0, 1'b1, "R4 table bit at last level");
        send(mkva(1,2,10,0), 2'd1, 1'b0, 1'b1, "R6 leaf above bound");
        send(mkva(1,2,11,0), 2'd1, 1'b0, 1'b1, "R6 leaf at bound");
        send(mkva(1,2,12,13'h1FFF), 2'd1, 1'b0, 1'b1, "R6 R8 leaf below bound");
        send(64'h5432, 2'd2, 1'b0, 1'b0, "R2 identity store");
        send(64'hFFFFF, 2'd0, 1'b1, 1'b0, "R2 last byte inside");
        send(64'h100000, 2'd1, 1'b0, 1'b0, "R2 at bound faults");
        send(64'hFFFF_0000_0000_0000, 2'd3, 1'b0, 1'b0, "R2 high address faults");
        send(mkva(1,2,3,0), 2'd2, 1'b0, 1'b1, "R10 walk after stalls");

        while (epa_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(addr_q.size() == 0, "R3 all expected reads issued", 64'(addr_q.size()), 64'd0);
        check(req_ready === 1'b1, "R1 idle at end", 64'(req_ready), 64'd1);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule